// File: doc/BRIEF.md
# Threshold FIFO pair with interrupt unit

This block sits between a software register port and a byte-serial bus engine. It holds one byte FIFO for outgoing data, filled by register writes and drained by the engine, and one for incoming data, filled by the engine and drained by register reads. Each FIFO has a programmable threshold. The transmit threshold sets a near-empty condition and the receive threshold sets a near-full condition. Either FIFO can be emptied by a flush. A flush is started by writing a control bit. The bit stays set while the flush runs for a fixed number of cycles, and the hardware then clears it.

An interrupt unit collects FIFO level conditions, a transmit overrun flag and four transaction events from the engine: done, done without stop, arbitration lost and bus error. It presents them as a raw status word at fixed bit positions. A mask register selects which bits reach the single interrupt line, and a write-one-to-clear register resets the sticky bits. Software reads all state through a flat word-indexed register port with combinational read data.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset both FIFOs are empty, both thresholds and the mask are zero, the control word reads 0, the raw status (index 5) reads 0x33 and irq is low.
- R2: Writes to index 3 push bytes into the transmit FIFO. The engine drains them in order with tx_pop, and tx_byte always shows the oldest byte. A pop of an empty FIFO is ignored. The level word (index 9) shows the transmit count in bits 4:0 and the receive count in bits 20:16. Each FIFO holds DEPTH (16) bytes.
- R3: Raw status bits that follow the FIFO levels are: bit 0 transmit empty, bit 1 transmit count at or below the transmit threshold (index 1, 4 bits, 0..15), bit 2 transmit full, bit 4 receive empty, bit 5 receive count at or above the receive threshold (index 2, 4 bits), bit 6 receive full. These bits track the levels and are not changed by writes to the clear register.
- R4: Writing 1 to control bit 0 (index 0) flushes the transmit FIFO, and writing 1 to bit 1 flushes the receive FIFO. The bit reads 1 for FLUSH_CYCLES cycles and then self-clears with that FIFO empty. Pushes and pops of that FIFO while it reads 1 are ignored.
- R5: A write to index 3 while the transmit FIFO holds DEPTH bytes is dropped and sets raw bit 3 (overrun). The bit stays set until cleared.
- R6: One-cycle pulses on evt_done, evt_done_nostop, evt_arb_lost and evt_bus_err set raw bits 19, 28, 24 and 25. Each bit stays set until cleared.
- R7: Writing a word to index 8 clears each sticky raw bit (3, 19, 24, 25, 28) whose position holds a 1. An event arriving in the same cycle as its clear leaves the bit set.
- R8: The mask (index 6) keeps only the implemented bits, so writing all ones reads back 0x1308007F. Masked status (index 7) is raw AND mask. Bits 31:29 and the unimplemented positions read 0.
- R9: irq is high exactly when the masked status is nonzero.
- R10: An rx_push while the receive FIFO is full is dropped. A read of index 4 returns the oldest received byte and removes it. A read of index 4 from an empty receive FIFO leaves the level at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive FIFO at index 4) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| tx_byte | output | DATA_W | Oldest transmit byte |
| tx_is_empty | output | 1 | Transmit FIFO holds no byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | DATA_W | Received byte |
| rx_is_full | output | 1 | Receive FIFO is full |
| evt_done | input | 1 | Transaction finished with stop |
| evt_done_nostop | input | 1 | Transaction finished without stop |
| evt_arb_lost | input | 1 | Arbitration lost |
| evt_bus_err | input | 1 | Bus error |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: DEPTH 16, DATA_W 8 and FLUSH_CYCLES 4. With a depth of 16, the full and overrun corners take only seventeen writes, and the 4-bit threshold range 0..15 covers every level but the full one. A flush length of 4 is long enough that a push issued while the flush runs falls inside it, and the number of cycles the control bit stays set can be counted exactly. Scoreboard queues give the expected byte order for both FIFOs across fills, drains, dropped writes and flushes.

// File: rtl/tfi_pkg.sv
package tfi_pkg;

   localparam int REG_W  = 32;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL   = 4'd0,
      A_TXTHR  = 4'd1,
      A_RXTHR  = 4'd2,
      A_TXDATA = 4'd3,
      A_RXDATA = 4'd4,
      A_RAW    = 4'd5,
      A_MASK   = 4'd6,
      A_MASKED = 4'd7,
      A_CLEAR  = 4'd8,
      A_LEVEL  = 4'd9
   } reg_idx_e;

   // status bit positions (software decodes these)
   localparam int B_TX_EMPTY = 0;
   localparam int B_TX_LOW   = 1;
   localparam int B_TX_FULL  = 2;
   localparam int B_TX_OVR   = 3;
   localparam int B_RX_EMPTY = 4;
   localparam int B_RX_HIGH  = 5;
   localparam int B_RX_FULL  = 6;
   localparam int B_DONE     = 19;
   localparam int B_ARB      = 24;
   localparam int B_BERR     = 25;
   localparam int B_DONE_NS  = 28;

   localparam logic [REG_W-1:0] LEVEL_BITS  = 32'h0000_0077;
   localparam logic [REG_W-1:0] STICKY_BITS = 32'h1308_0008;
   localparam logic [REG_W-1:0] CLEARABLE   = 32'h131F_007F;
   localparam logic [REG_W-1:0] IMPL_BITS   = LEVEL_BITS | STICKY_BITS;

   localparam int LEVEL_RX_LSB = 16;

endpackage

// File: rtl/tfi_fifo.sv
module tfi_fifo #(
   parameter int DATA_W       = 8,
   parameter int DEPTH        = 16,
   parameter int FLUSH_CYCLES = 4,
   parameter bit NEAR_HIGH    = 1'b0,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic              flush_req,
   input  logic [AW-1:0]     thr,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     count,
   output logic              empty,
   output logic              full,
   output logic              near,
   output logic              flushing
);

   localparam int FW = $clog2(FLUSH_CYCLES + 1);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("tfi_fifo: DEPTH must be a power of two, at least 2");
   end
   if (FLUSH_CYCLES < 2) begin : g_bad_flush
      $error("tfi_fifo: FLUSH_CYCLES must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [FW-1:0]     fl_cnt;
   logic              do_push, do_pop, fl_end;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full && !flushing;
   assign do_pop  = pop && !empty && !flushing;
   assign fl_end  = flushing && (fl_cnt == '0);
   assign head    = mem[rd_ptr];

   if (NEAR_HIGH) begin : g_near_high
      assign near = (count >= CW'(thr));
   end else begin : g_near_low
      assign near = (count <= CW'(thr));
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         flushing <= 1'b0;
         fl_cnt   <= '0;
      end else if (fl_end) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         flushing <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (flushing) begin
            fl_cnt <= fl_cnt - 1'b1;
         end else if (flush_req) begin
            flushing <= 1'b1;
            fl_cnt   <= FW'(FLUSH_CYCLES - 1);
         end
      end
   end

endmodule

// File: rtl/tfi_irq.sv
module tfi_irq
   import tfi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] level_in,
   input  logic [REG_W-1:0] event_in,
   input  logic             mask_we,
   input  logic             clr_we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] raw,
   output logic [REG_W-1:0] mask,
   output logic [REG_W-1:0] masked,
   output logic             irq
);

   logic [REG_W-1:0] flags;
   logic [REG_W-1:0] clr_vec;

   assign clr_vec = clr_we ? (wdata & CLEARABLE) : '0;

   // a set in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         mask  <= '0;
      end else begin
         flags <= ((flags & ~clr_vec) | event_in) & STICKY_BITS;
         if (mask_we) mask <= wdata & IMPL_BITS;
      end
   end

   assign raw    = (level_in & LEVEL_BITS) | flags;
   assign masked = raw & mask;
   assign irq    = |masked;

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
   import tfi_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int DEPTH        = 16,
   parameter int FLUSH_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_is_empty,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              rx_is_full,
   input  logic              evt_done,
   input  logic              evt_done_nostop,
   input  logic              evt_arb_lost,
   input  logic              evt_bus_err,
   output logic              irq
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_width
      $error("fifo_irq_unit: DATA_W must be 1..32");
   end
   if (CW > LEVEL_RX_LSB) begin : g_bad_level
      $error("fifo_irq_unit: DEPTH too large for the level word");
   end

   logic              wr_ctrl, wr_txthr, wr_rxthr, wr_txd, rd_rxd;
   logic [AW-1:0]     tx_thr_q, rx_thr_q;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_full, tx_low, tx_flushing;
   logic              rx_empty, rx_high, rx_flushing;
   logic [DATA_W-1:0] rx_head;
   logic              tx_ovr;
   logic [REG_W-1:0]  lvl_vec, evt_vec, raw, mask_q, masked;

   assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
   assign wr_txthr = reg_we && (reg_addr == A_TXTHR);
   assign wr_rxthr = reg_we && (reg_addr == A_RXTHR);
   assign wr_txd   = reg_we && (reg_addr == A_TXDATA);
   assign rd_rxd   = reg_re && (reg_addr == A_RXDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_thr_q <= '0;
         rx_thr_q <= '0;
      end else begin
         if (wr_txthr) tx_thr_q <= reg_wdata[AW-1:0];
         if (wr_rxthr) rx_thr_q <= reg_wdata[AW-1:0];
      end
   end

   tfi_fifo #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES), .NEAR_HIGH(1'b0)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_txd),
      .push_data (reg_wdata[DATA_W-1:0]),
      .pop       (tx_pop),
      .flush_req (wr_ctrl && reg_wdata[0]),
      .thr       (tx_thr_q),
      .head      (tx_byte),
      .count     (tx_cnt),
      .empty     (tx_is_empty),
      .full      (tx_full),
      .near      (tx_low),
      .flushing  (tx_flushing)
   );

   tfi_fifo #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES), .NEAR_HIGH(1'b1)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .push_data (rx_byte),
      .pop       (rd_rxd),
      .flush_req (wr_ctrl && reg_wdata[1]),
      .thr       (rx_thr_q),
      .head      (rx_head),
      .count     (rx_cnt),
      .empty     (rx_empty),
      .full      (rx_is_full),
      .near      (rx_high),
      .flushing  (rx_flushing)
   );

   // a write that finds the transmit side full is lost and flagged
   assign tx_ovr = wr_txd && tx_full && !tx_flushing;

   always_comb begin
      lvl_vec             = '0;
      lvl_vec[B_TX_EMPTY] = tx_is_empty;
      lvl_vec[B_TX_LOW]   = tx_low;
      lvl_vec[B_TX_FULL]  = tx_full;
      lvl_vec[B_RX_EMPTY] = rx_empty;
      lvl_vec[B_RX_HIGH]  = rx_high;
      lvl_vec[B_RX_FULL]  = rx_is_full;
      evt_vec             = '0;
      evt_vec[B_TX_OVR]   = tx_ovr;
      evt_vec[B_DONE]     = evt_done;
      evt_vec[B_DONE_NS]  = evt_done_nostop;
      evt_vec[B_ARB]      = evt_arb_lost;
      evt_vec[B_BERR]     = evt_bus_err;
   end

   tfi_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (lvl_vec),
      .event_in (evt_vec),
      .mask_we  (reg_we && (reg_addr == A_MASK)),
      .clr_we   (reg_we && (reg_addr == A_CLEAR)),
      .wdata    (reg_wdata),
      .raw      (raw),
      .mask     (mask_q),
      .masked   (masked),
      .irq      (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:   reg_rdata = {30'd0, rx_flushing, tx_flushing};
         A_TXTHR:  reg_rdata = REG_W'(tx_thr_q);
         A_RXTHR:  reg_rdata = REG_W'(rx_thr_q);
         A_RXDATA: reg_rdata = REG_W'(rx_head);
         A_RAW:    reg_rdata = raw;
         A_MASK:   reg_rdata = mask_q;
         A_MASKED: reg_rdata = masked;
         A_LEVEL: begin
            reg_rdata[CW-1:0]                       = tx_cnt;
            reg_rdata[LEVEL_RX_LSB+CW-1:LEVEL_RX_LSB] = rx_cnt;
         end
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/fifo_irq_unit_chk.sv
module fifo_irq_unit_chk
   import tfi_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [3:0]    reg_addr,
   input logic          irq,
   input logic          evt_arb_lost,
   input logic [CW-1:0] tx_cnt,
   input logic          tx_flushing,
   input logic [31:0]   raw,
   input logic [31:0]   mask_q
);

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH));

   a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_flushing) |-> (tx_cnt == '0));

   a_r4_flush_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_flushing) |=> tx_flushing);

   a_r5_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_TXDATA && tx_cnt == CW'(DEPTH) && !tx_flushing)
      |=> raw[B_TX_OVR]);

   a_r6_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      evt_arb_lost |=> raw[B_ARB]);

   a_r8_mask_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == A_MASK) |=> $stable(mask_q));

   a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((raw & mask_q) != '0));

endmodule

bind fifo_irq_unit fifo_irq_unit_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .irq          (irq),
   .evt_arb_lost (evt_arb_lost),
   .tx_cnt       (tx_cnt),
   .tx_flushing  (tx_flushing),
   .raw          (raw),
   .mask_q       (mask_q)
);

// File: tb/fifo_irq_unit_bench.sv
module fifo_irq_unit_bench;

   localparam int DW = 8;
   localparam int DEPTH = 16;
   localparam int FLC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_pop = 1'b0;
   logic [DW-1:0] tx_byte;
   logic        tx_is_empty;
   logic        rx_push = 1'b0;
   logic [DW-1:0] rx_byte = '0;
   logic        rx_is_full;
   logic        evt_done = 1'b0, evt_done_nostop = 1'b0;
   logic        evt_arb_lost = 1'b0, evt_bus_err = 1'b0;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [DW-1:0] txq[$];
   logic [DW-1:0] rxq[$];

   always #2.5 clk = ~clk;

   fifo_irq_unit #(.DATA_W(DW), .DEPTH(DEPTH), .FLUSH_CYCLES(FLC)) u_fifo_irq_unit (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_is_empty(tx_is_empty),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_is_full(rx_is_full),
      .evt_done(evt_done), .evt_done_nostop(evt_done_nostop),
      .evt_arb_lost(evt_arb_lost), .evt_bus_err(evt_bus_err), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_re = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   // driver: transmit side write, expected byte queued if it fits
   task automatic tx_write(input logic [DW-1:0] b);
      if (txq.size() < DEPTH) txq.push_back(b);
      wr(4'd3, 32'(b));
   endtask

   // monitor: engine takes a byte, compared with the queue head
   task automatic tx_take(input string req);
      logic [DW-1:0] e;
      e = txq.pop_front();
      #1 check(tx_byte == e, req, 32'(tx_byte), 32'(e));
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic rx_feed(input logic [DW-1:0] b);
      if (rxq.size() < DEPTH) rxq.push_back(b);
      rx_push = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic rx_take(input string req);
      logic [DW-1:0] e;
      logic [31:0] d;
      e = rxq.pop_front();
      rd(4'd4, d);
      check(d[DW-1:0] == e, req, d, 32'(e));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int ones;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd5, d); check(d == 32'h33, "R1 raw", d, 32'h33);
      rd(4'd9, d); check(d == 0, "R1 level", d, 0);
      rd(4'd0, d); check(d == 0, "R1 ctrl", d, 0);
      rd(4'd6, d); check(d == 0, "R1 mask", d, 0);
      rd(4'd1, d); check(d == 0, "R1 tx thr", d, 0);
      check(irq == 1'b0, "R1 irq", 32'(irq), 0);

      // R2/R3 transmit path and near-empty boundary
      for (int i = 0; i < 5; i++) tx_write(8'h10 + 8'(i));
      rd(4'd9, d); check(d[4:0] == 5, "R2 tx level", d, 5);
      rd(4'd5, d); check(d[1:0] == 2'b00, "R3 tx not low thr0", d, 0);
      wr(4'd1, 32'd5);
      rd(4'd5, d); check(d[1] == 1'b1, "R3 tx low at thr", d, 32'h2);
      wr(4'd4 - 4'd3, 32'd4);
      rd(4'd5, d); check(d[1] == 1'b0, "R3 tx not low above thr", d, 0);
      for (int i = 0; i < 5; i++) tx_take("R2 tx order");
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
      rd(4'd9, d); check(d[4:0] == 0, "R2 pop empty ignored", d, 0);

      // R5 overrun and R3 full
      for (int i = 0; i < DEPTH; i++) tx_write(8'hA0 + 8'(i));
      rd(4'd5, d); check(d[2] == 1'b1 && d[3] == 1'b0, "R3 tx full", d, 32'h4);
      tx_write(8'hEE);
      rd(4'd5, d); check(d[3] == 1'b1, "R5 overrun flag", d, 32'h8);
      rd(4'd9, d); check(d[4:0] == 5'd16, "R5 level kept", d, 16);
      wr(4'd6, 32'h8);
      #1 check(irq == 1'b1, "R9 irq on overrun", 32'(irq), 1);
      rd(4'd7, d); check(d == 32'h8, "R8 masked", d, 32'h8);
      wr(4'd8, 32'hFFFF_FFFF);
      rd(4'd5, d); check(d[3] == 1'b0 && d[2] == 1'b1 && d[4] == 1'b1,
                         "R7 R3 clear keeps levels", d, 32'h34);
      #1 check(irq == 1'b0, "R9 irq drops", 32'(irq), 0);
      for (int i = 0; i < DEPTH; i++) tx_take("R5 tx order after drop");

      // R8 mask implemented bits
      wr(4'd6, 32'hFFFF_FFFF);
      rd(4'd6, d); check(d == 32'h1308_007F, "R8 mask bits", d, 32'h1308_007F);
      wr(4'd6, 32'h0);

      // R6 events
      evt_arb_lost = 1'b1; @(negedge clk); evt_arb_lost = 1'b0;
      evt_done = 1'b1; @(negedge clk); evt_done = 1'b0;
      evt_done_nostop = 1'b1; @(negedge clk); evt_done_nostop = 1'b0;
      evt_bus_err = 1'b1; @(negedge clk); evt_bus_err = 1'b0;
      repeat (2) @(negedge clk);
      rd(4'd5, d); check(d[31:7] == 25'(32'h1308_0000 >> 7), "R6 sticky events", d, 32'h1308_0033);
      wr(4'd6, 32'h0100_0000);
      #1 check(irq == 1'b1, "R9 irq on arb", 32'(irq), 1);
      wr(4'd8, 32'h0100_0000);
      rd(4'd5, d); check(d[24] == 1'b0 && d[19] == 1'b1 && d[25] == 1'b1 && d[28] == 1'b1,
                         "R7 clear one bit", d, 32'h1208_0033);
      #1 check(irq == 1'b0, "R9 irq after clear", 32'(irq), 0);
      // R7 set wins over same-cycle clear
      wr(4'd8, 32'h1208_0000);
      evt_done = 1'b1; reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 32'h0008_0000;
      @(negedge clk);
      evt_done = 1'b0; reg_we = 1'b0;
      rd(4'd5, d); check(d[19] == 1'b1, "R7 set wins", d, 32'h0008_0033);
      wr(4'd8, 32'h0008_0000);
      rd(4'd5, d); check(d == 32'h33, "R7 all clear", d, 32'h33);
      wr(4'd6, 32'h0);

      // R10 / R3 receive path
      wr(4'd2, 32'd3);
      rx_feed(8'h51); rx_feed(8'h52);
      rd(4'd5, d); check(d[5] == 1'b0, "R3 rx below thr", d, 0);
      rx_feed(8'h53);
      rd(4'd5, d); check(d[5] == 1'b1, "R3 rx at thr", d, 32'h20);
      for (int i = 3; i < DEPTH + 1; i++) rx_feed(8'h60 + 8'(i));
      rd(4'd9, d); check(d[20:16] == 5'd16, "R10 rx full dropped", d, 32'h10_0000);
      rd(4'd5, d); check(d[6] == 1'b1, "R3 rx full bit", d, 32'h40);
      for (int i = 0; i < DEPTH; i++) rx_take("R10 rx order");
      reg_re = 1'b1; reg_addr = 4'd4; @(negedge clk); reg_re = 1'b0;
      rd(4'd9, d); check(d[20:16] == 0, "R10 read empty", d, 0);

      // R4 transmit flush
      for (int i = 0; i < 4; i++) tx_write(8'hC0 + 8'(i));
      wr(4'd0, 32'h1);
      wr(4'd3, 32'hAB);
      ones = 0;
      for (int i = 0; i < 20; i++) begin
         rd(4'd0, d);
         if (d[0]) ones++;
         else break;
      end
      check(ones == FLC - 1, "R4 flush bit duration", ones, FLC - 1);
      rd(4'd9, d); check(d[4:0] == 0, "R4 tx flushed", d, 0);
      txq.delete();
      tx_write(8'h77);
      tx_take("R4 tx usable after flush");

      // R4 receive flush
      rx_feed(8'h01); rx_feed(8'h02);
      wr(4'd0, 32'h2);
      rd(4'd0, d); check(d == 32'h2, "R4 rx flush bit", d, 32'h2);
      repeat (FLC + 1) @(negedge clk);
      rd(4'd0, d); check(d == 0, "R4 rx flush self clear", d, 0);
      rd(4'd9, d); check(d[20:16] == 0, "R4 rx flushed", d, 0);
      rxq.delete();

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule